// File: doc/BRIEF.md
# Scanned Key Matrix Encoder with Key Queue

This block walks a set of scan lines across a matrix of up to 64 keys and reads the column return lines once per scan step. A closure only counts once the same key is seen again on the next visit to its row. An accepted key becomes one byte that records the column, the row and the states of the shift and control keys at that moment. The byte goes into a small first-in first-out queue.

A processor drains the queue through a one-bit-address read port. It can also read a status byte that shows the fill level, a full flag and a sticky overrun flag. An interrupt line is high whenever the queue holds at least one byte, so the block can be driven by interrupts or by polling.

The scan lines run in one of two forms. One form is a plain binary row count that external logic decodes. The other is a one-of-four pattern decoded inside the block, which limits the scan to four rows.

Top module: `kbd_encoder`

## Requirements
- R1: With `scan_decoded_i` low, the row count advances by one every TICK_DIV clock cycles, wraps from ROWS-1 to 0, and `scan_o` carries that count in binary with its unused upper bits zero.
- R2: With `scan_decoded_i` high, only rows 0 to 3 are scanned, `scan_o` shows exactly one active-high line (bit n for row n), and keys in rows 4 and above are never queued.
- R3: A key is queued only if it reads as pressed on two consecutive visits to its row. A press seen on a single visit queues nothing.
- R4: A queued byte holds control in bit 7, shift in bit 6, the row in bits 5:3 and the column in bits 2:0. Shift and control are taken at the moment the key is accepted.
- R5: A key that stays held is queued once. It can be queued again only after one visit has seen it released.
- R6: When several keys in one row are confirmed on the same visit, the lowest column is queued first, one key per visit. The rest follow on later visits.
- R7: A read with `rd_addr_i` = 0 pops the oldest byte, which appears on `rd_data_o` one cycle later. Reading an empty queue returns 0x00 and changes nothing.
- R8: A read with `rd_addr_i` = 1 returns status one cycle later: bit 7 overrun, bit 6 full, bits 5:0 the number of queued bytes.
- R9: A key accepted while the queue holds DEPTH bytes is discarded and sets overrun. Overrun stays set until a status read, which returns it as 1 and then clears it.
- R10: `irq_o` is high exactly when the queue was non-empty on the previous cycle.
- R11: After reset the queue is empty, overrun is clear, `irq_o` is low and the scan starts at row 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_decoded_i | input | 1 | 1 selects the one-of-four scan form, 0 the binary count |
| scan_o | output | SCAN_W | Scan lines to the matrix |
| ret_i | input | COLS | Return lines, 1 means the key in the scanned row is closed |
| shift_i | input | 1 | Shift key state |
| ctrl_i | input | 1 | Control key state |
| rd_stb_i | input | 1 | Read request, one cycle |
| rd_addr_i | input | 1 | 0 key data (pops), 1 status |
| rd_data_o | output | CODE_W | Read result, valid the cycle after the request |
| irq_o | output | 1 | High while the queue holds data |

## Verification
The bench builds the block with ROWS = 8, COLS = 8, DEPTH = 8 and TICK_DIV = 4. With those values a full scan frame is 32 cycles, so many frames fit in a short run. Single-visit glitches, priority among columns in one row, and filling the queue past its depth can all be reached in a few hundred cycles each. The bench models the key matrix by reading `scan_o` back into the return lines, so both scan forms are exercised against the same key model.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  typedef enum logic {
    SEL_DATA   = 1'b0,
    SEL_STATUS = 1'b1
  } rd_sel_e;
endpackage

// File: rtl/kbd_scan_timer.sv
module kbd_scan_timer #(
  parameter int ROWS     = 8,
  parameter int TICK_DIV = 64,
  parameter int SCAN_W   = 4,
  localparam int ROW_W   = $clog2(ROWS),
  localparam int DIV_W   = $clog2(TICK_DIV)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              decoded,
  output logic              tick,
  output logic [ROW_W-1:0]  row,
  output logic [SCAN_W-1:0] scan
);
  logic [DIV_W-1:0] div_q;
  logic [ROW_W-1:0] last_row;
  logic [SCAN_W-1:0] pattern;

  // scan step ends on the last divider cycle
  assign tick     = (div_q == DIV_W'(TICK_DIV - 1));
  assign last_row = decoded ? ROW_W'(3) : ROW_W'(ROWS - 1);

  always_comb begin
    if (decoded) pattern = SCAN_W'(1) << row[1:0];
    else         pattern = SCAN_W'(row);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      row   <= '0;
      scan  <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) row <= (row >= last_row) ? '0 : row + 1'b1;
      scan <= pattern;
    end
  end
endmodule

// File: rtl/kbd_debounce.sv
module kbd_debounce #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int COL_W  = $clog2(COLS),
  localparam int CODE_W = 2 + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ROW_W-1:0]  row,
  input  logic [COLS-1:0]   ret,
  input  logic              shift,
  input  logic              ctrl,
  output logic              push,
  output logic [CODE_W-1:0] code
);
  logic [COLS-1:0]  seen_q [ROWS];
  logic [COLS-1:0]  rep_q  [ROWS];
  logic [COLS-1:0]  hit, grant;
  logic [COL_W-1:0] sel;
  logic             any;

  // confirmed on this visit and not yet reported
  always_comb begin
    hit = ret & seen_q[row] & ~rep_q[row];
    any = |hit;
    sel = '0;
    for (int c = COLS - 1; c >= 0; c--) begin
      if (hit[c]) sel = COL_W'(c);
    end
    grant = any ? (COLS'(1) << sel) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++) begin
        seen_q[r] <= '0;
        rep_q[r]  <= '0;
      end
      push <= 1'b0;
      code <= '0;
    end else begin
      push <= 1'b0;
      if (tick) begin
        seen_q[row] <= ret;
        rep_q[row]  <= (rep_q[row] | grant) & ret;
        push        <= any;
        code        <= {ctrl, shift, row, sel};
      end
    end
  end
endmodule

// File: rtl/kbd_fifo.sv
module kbd_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             drop
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             wr_ok, rd_ok;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign wr_ok = push & ~full;
  assign rd_ok = pop & ~empty;
  assign drop  = push & full;

  // storage without reset, registered read port
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= din;
    if (rd_ok) dout <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (rd_ok) rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/kbd_encoder.sv
module kbd_encoder
  import kbd_pkg::*;
#(
  parameter int ROWS     = 8,
  parameter int COLS     = 8,
  parameter int DEPTH    = 8,
  parameter int TICK_DIV = 64,
  localparam int ROW_W   = $clog2(ROWS),
  localparam int COL_W   = $clog2(COLS),
  localparam int CODE_W  = 2 + ROW_W + COL_W,
  localparam int SCAN_W  = (ROW_W > 4) ? ROW_W : 4,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_decoded_i,
  output logic [SCAN_W-1:0] scan_o,
  input  logic [COLS-1:0]   ret_i,
  input  logic              shift_i,
  input  logic              ctrl_i,
  input  logic              rd_stb_i,
  input  logic              rd_addr_i,
  output logic [CODE_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic              tick;
  logic [ROW_W-1:0]  row;
  logic              key_push;
  logic [CODE_W-1:0] key_code;
  logic              pop, stat_rd;
  logic [CODE_W-1:0] fifo_dout;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              fifo_full, fifo_empty, fifo_drop;
  logic              ovr_q, sel_q, zero_q;
  logic [CODE_W-1:0] stat_q;

  kbd_scan_timer #(.ROWS(ROWS), .TICK_DIV(TICK_DIV), .SCAN_W(SCAN_W)) u_scan (
    .clk(clk), .rst(rst), .decoded(scan_decoded_i),
    .tick(tick), .row(row), .scan(scan_o)
  );

  kbd_debounce #(.ROWS(ROWS), .COLS(COLS)) u_deb (
    .clk(clk), .rst(rst), .tick(tick), .row(row), .ret(ret_i),
    .shift(shift_i), .ctrl(ctrl_i), .push(key_push), .code(key_code)
  );

  kbd_fifo #(.W(CODE_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(key_push), .din(key_code), .pop(pop),
    .dout(fifo_dout), .count(fifo_cnt), .full(fifo_full),
    .empty(fifo_empty), .drop(fifo_drop)
  );

  assign pop     = rd_stb_i & (rd_addr_i == SEL_DATA);
  assign stat_rd = rd_stb_i & (rd_addr_i == SEL_STATUS);

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q  <= 1'b0;
      sel_q  <= SEL_DATA;
      zero_q <= 1'b1;
      stat_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= ~fifo_empty;
      // a discard in the same cycle as a status read wins
      ovr_q <= fifo_drop | (ovr_q & ~stat_rd);
      if (rd_stb_i) sel_q <= rd_addr_i;
      if (stat_rd)  stat_q <= {ovr_q, fifo_full, (CODE_W - 2)'(fifo_cnt)};
      if (pop)      zero_q <= fifo_empty;
    end
  end

  assign rd_data_o = sel_q ? stat_q : (zero_q ? '0 : fifo_dout);
endmodule

// File: rtl/kbd_encoder_chk.sv
module kbd_encoder_chk #(
  parameter int DEPTH  = 8,
  parameter int SCAN_W = 4,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              scan_decoded_i,
  input logic [SCAN_W-1:0] scan_o,
  input logic              irq_o,
  input logic              rd_stb_i,
  input logic              rd_addr_i,
  input logic [CNT_W-1:0]  fifo_cnt,
  input logic              ovr_q
);
  a_r2_decoded_onehot: assert property (@(posedge clk) disable iff (rst)
    $past(scan_decoded_i) |-> $onehot0(scan_o));

  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= CNT_W'(DEPTH));

  a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
    (fifo_cnt == $past(fifo_cnt)) ||
    (fifo_cnt == CNT_W'($past(fifo_cnt) + 1'b1)) ||
    (CNT_W'(fifo_cnt + 1'b1) == $past(fifo_cnt)));

  a_r10_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    irq_o == ($past(fifo_cnt) != '0));

  a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    ($past(ovr_q) && !($past(rd_stb_i) && $past(rd_addr_i))) |-> ovr_q);
endmodule

bind kbd_encoder kbd_encoder_chk #(.DEPTH(DEPTH), .SCAN_W(SCAN_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .scan_decoded_i(scan_decoded_i), .scan_o(scan_o),
  .irq_o(irq_o), .rd_stb_i(rd_stb_i), .rd_addr_i(rd_addr_i),
  .fifo_cnt(fifo_cnt), .ovr_q(ovr_q)
);

// File: tb/kbd_encoder_tb_top.sv
module kbd_encoder_tb_top;
  localparam int ROWS = 8, COLS = 8, DEPTH = 8, TICK_DIV = 4;
  localparam int FRAME = ROWS * TICK_DIV;

  logic clk = 1'b0, rst = 1'b1;
  logic decoded = 1'b0, shift = 1'b0, ctrl = 1'b0;
  logic rd_stb = 1'b0, rd_addr = 1'b0;
  logic [3:0] scan;
  logic [COLS-1:0] ret;
  logic [7:0] rd_data;
  logic irq;
  logic [COLS-1:0] key_m [ROWS];
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  kbd_encoder #(.ROWS(ROWS), .COLS(COLS), .DEPTH(DEPTH), .TICK_DIV(TICK_DIV)) dut_i (
    .clk(clk), .rst(rst), .scan_decoded_i(decoded), .scan_o(scan), .ret_i(ret),
    .shift_i(shift), .ctrl_i(ctrl), .rd_stb_i(rd_stb), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  // key matrix model driven from the scan lines
  always_comb begin
    ret = '0;
    if (decoded) begin
      case (scan)
        4'b0001: ret = key_m[0];
        4'b0010: ret = key_m[1];
        4'b0100: ret = key_m[2];
        4'b1000: ret = key_m[3];
        default: ret = '0;
      endcase
    end else begin
      ret = key_m[scan[2:0]];
    end
  end

  function automatic logic [7:0] kcode(logic c, logic s, int r, int col);
    return {c, s, 3'(r), 3'(col)};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); rd_stb = 1'b1; rd_addr = a;
    @(negedge clk); rd_stb = 1'b0; d = rd_data;
  endtask

  task automatic frames(int n);
    repeat (n * FRAME) @(negedge clk);
  endtask

  task automatic clear_keys();
    for (int r = 0; r < ROWS; r++) key_m[r] = '0;
  endtask

  task automatic wait_row(int r);
    while (scan == 4'(r)) @(negedge clk);
    while (scan != 4'(r)) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [3:0] prev;
    int cnt;
    void'($urandom(32'h5eed_1234));
    clear_keys();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 scan", {4'b0, scan}, 8'h00);
    chk("R11 irq", {7'b0, irq}, 8'h00);
    rd(1'b1, d); chk("R11 status", d, 8'h00);
    rd(1'b0, d); chk("R7 empty read", d, 8'h00);
    rd(1'b1, d); chk("R7 empty read no change", d, 8'h00);

    // R1 binary scan timing and order
    prev = scan;
    while (scan == prev) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      prev = scan; cnt = 0;
      do begin @(negedge clk); cnt++; end while (scan == prev);
      chk("R1 step period", 8'(cnt), 8'(TICK_DIV));
      chk("R1 next row", {4'b0, scan}, {5'b0, 3'(prev + 1)});
    end

    // R2 decoded scan pattern
    decoded = 1'b1;
    frames(1);
    prev = scan;
    while (scan == prev) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      prev = scan;
      while (scan == prev) @(negedge clk);
      chk("R2 one-of-four", {4'b0, scan}, {4'b0, prev[2:0], prev[3]});
    end
    key_m[5][3] = 1'b1;
    frames(3);
    rd(1'b1, d); chk("R2 row above 3 ignored", d, 8'h00);
    clear_keys();
    shift = 1'b1;
    key_m[2][4] = 1'b1;
    frames(3);
    clear_keys(); frames(2);
    rd(1'b0, d); chk("R2 decoded key code", d, kcode(0, 1, 2, 4));
    shift = 1'b0;
    decoded = 1'b0;
    frames(2);

    // R3 single-visit press is not queued
    wait_row(2);
    key_m[2][5] = 1'b1;
    while (scan == 4'd2) @(negedge clk);
    clear_keys();
    frames(3);
    rd(1'b1, d); chk("R3 glitch not queued", d, 8'h00);

    // R4 and R5: held key queued once, again after release
    ctrl = 1'b1;
    key_m[6][7] = 1'b1;
    frames(5);
    clear_keys(); frames(2);
    rd(1'b1, d); chk("R5 held once", d, 8'h01);
    rd(1'b0, d); chk("R4 code layout", d, kcode(1, 0, 6, 7));
    key_m[6][7] = 1'b1;
    frames(3);
    clear_keys(); frames(2);
    rd(1'b0, d); chk("R5 requeue after release", d, kcode(1, 0, 6, 7));
    ctrl = 1'b0;

    // R6 lowest column first within one row
    key_m[3][5] = 1'b1; key_m[3][1] = 1'b1;
    frames(4);
    clear_keys(); frames(2);
    rd(1'b0, d); chk("R6 first column", d, kcode(0, 0, 3, 1));
    rd(1'b0, d); chk("R6 second column", d, kcode(0, 0, 3, 5));

    // R9, R8, R10 overrun and status
    wait_row(0);
    for (int r = 0; r < ROWS; r++) key_m[r][0] = 1'b1;
    key_m[0][1] = 1'b1;
    frames(4);
    clear_keys(); frames(2);
    chk("R10 irq while data", {7'b0, irq}, 8'h01);
    rd(1'b1, d); chk("R9 overrun status", d, 8'hC8);
    rd(1'b1, d); chk("R8 overrun cleared", d, 8'h48);
    for (int r = 0; r < ROWS; r++) begin
      rd(1'b0, d); chk("R7 order", d, kcode(0, 0, r, 0));
    end
    @(negedge clk);
    chk("R10 irq low when empty", {7'b0, irq}, 8'h00);
    rd(1'b1, d); chk("R8 empty status", d, 8'h00);

    // random single keys
    for (int i = 0; i < 16; i++) begin
      int r, c;
      logic s, k;
      r = int'($urandom_range(ROWS - 1));
      c = int'($urandom_range(COLS - 1));
      s = 1'($urandom); k = 1'($urandom);
      shift = s; ctrl = k;
      key_m[r][c] = 1'b1;
      frames(3);
      clear_keys(); frames(2);
      rd(1'b0, d); chk("R4 random code", d, kcode(k, s, r, c));
      rd(1'b1, d); chk("R5 single entry", d, 8'h00);
    end

    summary();
    $finish;
  end
endmodule